// File: doc/BRIEF.md
# Idle Gap Balancer for a 32-bit-Lane Transmit Path

This block sits beside the transmit framer of a 10G Ethernet MAC whose start characters must always fall on lane 0 of a four-lane word. When a frame finishes, the framer reports the frame length modulo 4 with a one-cycle valid pulse. The block answers with the number of idle bytes to place before the next start character. It also keeps a small deficit state between frames, so that the gaps it picks average at least 12 bytes.

The gap ranges from 9 to 15 bytes. A short gap is allowed only while the deficit stays within 3 bytes. Once the deficit would pass 3, the block inserts extra idles and pays the deficit back. The answer is registered and appears one cycle after the request, qualified by a done strobe. A synchronous clear input returns the deficit to zero between link sessions.

Top module: `dic_gap_gen`

## Requirements
- R1: Under reset the deficit count is 0, the done strobe is low and the reported gap is 12; reset is synchronous and active-high.
- R2: A valid pulse with remainder 0 returns a gap of 12 and leaves the deficit count unchanged.
- R3: A valid pulse with remainder r (1 to 3) and count c where c + r <= 3 returns a gap of 12 - r and a new count of c + r.
- R4: A valid pulse with remainder r (1 to 3) and count c where c + r > 3 returns a gap of 16 - r and a new count of c + r - 4.
- R5: The gap and the new count appear on the outputs in the cycle after the valid pulse, and done is high for exactly that one cycle. With no valid pulse, done is low and the count holds its value.
- R6: Every reported gap lies between 9 and 15. The sum of the reported gaps since the last reset or clear is never less than 12 times the number of gaps minus 3.
- R7: Clear resets the count to 0 one cycle later. Clear takes priority over a valid pulse in the same cycle, and no done strobe is raised in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of the deficit count |
| eof_vld_i | input | 1 | Frame-end pulse qualifying eof_rem_i |
| eof_rem_i | input | 2 | Frame length modulo 4 |
| gap_vld_o | output | 1 | One-cycle strobe marking a new gap answer |
| gap_len_o | output | 4 | Idle bytes to insert, 9 to 15 |
| deficit_o | output | 2 | Deficit count after the answer |

## Verification
The assertions assume that eof_rem_i is stable whenever eof_vld_i is high. They also assume that clr_i and eof_vld_i are otherwise free, so back-to-back pulses and a clear in the same cycle as a pulse are legal. The stimulus drives both inputs from the bench's negative-edge tasks. It mixes random pulse spacing, back-to-back pulses and collisions with clear. Directed sequences drive each count into every remainder.

// File: rtl/dic_pkg.sv
package dic_pkg;
    localparam int LANES      = 4;
    localparam int REM_W      = $clog2(LANES);
    localparam int NOM_GAP    = 12;
    localparam int GAP_W      = 4;
    localparam int CNT_W      = REM_W;
    localparam int MAX_CREDIT = LANES - 1;

    typedef logic [REM_W-1:0] rem_t;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [GAP_W-1:0] gap_t;

    typedef struct packed {
        gap_t gap;
        cnt_t cnt;
    } gap_dec_t;

    function automatic gap_dec_t dic_step(input cnt_t c, input rem_t r);
        gap_dec_t d;
        int sum;
        sum = int'(c) + int'(r);
        if (sum <= MAX_CREDIT) begin
            d.gap = gap_t'(NOM_GAP - int'(r));
            d.cnt = cnt_t'(sum);
        end else begin
            d.gap = gap_t'(NOM_GAP + LANES - int'(r));
            d.cnt = cnt_t'(sum - LANES);
        end
        return d;
    endfunction
endpackage

// File: rtl/dic_decide.sv
module dic_decide
    import dic_pkg::*;
(
    input  cnt_t     cnt_i,
    input  rem_t     rem_i,
    output gap_dec_t dec_o
);
    always_comb begin
        dec_o = dic_step(cnt_i, rem_i);
    end
endmodule

// File: rtl/dic_state.sv
module dic_state
    import dic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_i,
    input  logic     upd_i,
    input  gap_dec_t dec_i,
    output cnt_t     cnt_o,
    output gap_t     gap_o,
    output logic     vld_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_o <= '0;
            gap_o <= gap_t'(NOM_GAP);
            vld_o <= 1'b0;
        end else begin
            vld_o <= upd_i;
            if (upd_i) begin
                cnt_o <= dec_i.cnt;
                gap_o <= dec_i.gap;
            end
        end
    end

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd_i && !clr_i) |=> $stable(cnt_o));
    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_o == '0 && !vld_o));
endmodule

// File: rtl/dic_gap_gen.sv
module dic_gap_gen
    import dic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr_i,
    input  logic        eof_vld_i,
    input  logic [1:0]  eof_rem_i,
    output logic        gap_vld_o,
    output logic [3:0]  gap_len_o,
    output logic [1:0]  deficit_o
);
    cnt_t     cnt;
    gap_t     gap;
    gap_dec_t dec;

    dic_decide u_decide (
        .cnt_i (cnt),
        .rem_i (rem_t'(eof_rem_i)),
        .dec_o (dec)
    );

    dic_state u_state (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr_i),
        .upd_i (eof_vld_i),
        .dec_i (dec),
        .cnt_o (cnt),
        .gap_o (gap),
        .vld_o (gap_vld_o)
    );

    assign gap_len_o = gap;
    assign deficit_o = cnt;

    // R6
    gap_range_chk: assert property (@(posedge clk) disable iff (rst)
        gap_vld_o |-> (gap_len_o >= 4'd9 && gap_len_o <= 4'd15));
    // R2
    zero_rem_chk: assert property (@(posedge clk) disable iff (rst || clr_i)
        (eof_vld_i && eof_rem_i == 2'd0) |=> (gap_len_o == 4'd12 && deficit_o == $past(deficit_o)));
    // R3 R4
    gap_plus_count_chk: assert property (@(posedge clk) disable iff (rst || clr_i)
        (eof_vld_i && eof_rem_i != 2'd0) |=>
        ((5'(gap_len_o) + 5'(deficit_o)) == (5'd12 + 5'($past(deficit_o)))));
    // R5
    strobe_follows_chk: assert property (@(posedge clk) disable iff (rst || clr_i)
        eof_vld_i |=> gap_vld_o);
    // R5
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !eof_vld_i |=> !gap_vld_o);
endmodule

// File: tb/dic_gap_gen_bench.sv
module dic_gap_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst, clr, vld;
    logic [1:0] rem;
    logic gvld;
    logic [3:0] glen;
    logic [1:0] dcnt;

    int n_chk = 0, n_err = 0;
    int mc = 0;
    int gsum = 0, gnum = 0;
    logic [31:0] seed_dummy;

    always #(CLK_PERIOD/2) clk = ~clk;

    dic_gap_gen u_dic_gap_gen (
        .clk(clk), .rst(rst), .clr_i(clr), .eof_vld_i(vld),
        .eof_rem_i(rem), .gap_vld_o(gvld), .gap_len_o(glen), .deficit_o(dcnt)
    );

    function automatic int exp_gap(int c, int r);
        if (r == 0) return 12;
        if (c + r <= 3) return 12 - r;
        return 16 - r;
    endfunction

    function automatic int exp_cnt(int c, int r);
        if (c + r <= 3) return c + r;
        return c + r - 4;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at negedge, sample result at next negedge (one register)
    task automatic pulse(int r, bit do_clr);
        string tag;
        int eg, ec;
        vld = 1'b1; rem = 2'(r); clr = do_clr;
        @(negedge clk);
        vld = 1'b0; clr = 1'b0;
        if (do_clr) begin
            check("R7 cnt", dcnt, 0);
            check("R7 strobe", gvld, 0);
            mc = 0; gsum = 0; gnum = 0;
        end else begin
            eg = exp_gap(mc, r); ec = exp_cnt(mc, r);
            tag = (r == 0) ? "R2" : ((mc + r <= 3) ? "R3" : "R4");
            check({tag, " gap"}, glen, eg);
            check({tag, " cnt"}, dcnt, ec);
            check("R5 strobe", gvld, 1);
            mc = ec;
            gsum += eg; gnum++;
            n_chk++;
            if (glen < 9 || glen > 15 || gsum < 12*gnum - 3) begin
                n_err++;
                $display("FAIL R6 actual=%0d expected>=%0d", gsum, 12*gnum - 3);
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R5 idle strobe", gvld, 0);
            check("R5 idle hold", dcnt, mc);
        end
    endtask

    initial begin
        seed_dummy = $urandom(32'd1234);
        rst = 1'b1; clr = 1'b0; vld = 1'b0; rem = 2'd0;
        repeat (3) @(negedge clk);
        check("R1 cnt", dcnt, 0);
        check("R1 strobe", gvld, 0);
        check("R1 gap", glen, 12);
        rst = 1'b0;
        @(negedge clk);
        // directed: every count against every remainder
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                pulse(0, 1'b1);
                if (c > 0) pulse(c, 1'b0);
                pulse(r, 1'b0);
                idle(1);
            end
        end
        // known corners
        pulse(0, 1'b1); pulse(3, 1'b0); pulse(1, 1'b0);
        check("R4 corner cnt", dcnt, 0);
        check("R4 corner gap", glen, 15);
        // clear collides with pulse
        pulse(2, 1'b0); pulse(3, 1'b1);
        idle(2);
        // random
        for (int i = 0; i < 3000; i++) begin
            int k;
            k = int'($urandom_range(0, 19));
            if (k == 0) pulse(int'($urandom_range(0, 3)), 1'b1);
            else if (k < 4) idle(int'($urandom_range(1, 3)));
            else pulse(int'($urandom_range(0, 3)), 1'b0);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule